// File: doc/BRIEF.md
# Fetch Instruction Queue with Immediate Folding

This block buffers instructions between instruction memory and the decoder. Each fetch delivers a bundle of two 16-bit instructions together with the address of the first one. Before anything is stored, prefix instructions are recognised and their payloads are merged into a 32-bit immediate. That immediate travels with the next real instruction, so prefixes never take a queue slot. The decoder reads one entry per cycle through a valid/ready handshake. Each entry carries the instruction, its folded immediate, two flag bits and its own PC, so an interrupt can restart at the exact instruction.

Two states govern the queue. In `ST_STREAM` the queue behaves as a FIFO. The engage transition to `ST_LOOP` is taken when `loop_go` names a short body that is already resident. In `ST_LOOP` the body is replayed from storage with no fetches until the release transition, which is a flush and returns the queue to `ST_STREAM`. In both states a flush empties the queue in one cycle, for example after a redirect.

Top module: `insn_queue`

## Requirements
- R1: After reset the queue is empty and in `ST_STREAM`: `dec_valid` is 0 and `fetch_ready` is 1.
- R2: Real (non-prefix) instructions reach the decode port in program order, slot 0 before slot 1. Each carries its own PC: the bundle PC for slot 0 and the bundle PC + 2 for slot 1.
- R3: An instruction is a prefix when bits [15:12] equal 4'hF, and its payload is bits [11:0]. Each prefix sets accumulator = (accumulator << 12) | payload, keeping the low 32 bits; the first prefix starts from 0. The accumulated value is delivered on `dec_imm` with the next real instruction. A prefix occupies no entry, and the accumulator is cleared once it has been attached.
- R4: `dec_flags[0]` is 1 when the entry carries a folded immediate, and `dec_flags[1]` is 1 when two or more prefixes built it. With no prefix, `dec_imm` is 0 and both flags are 0.
- R5: A partial immediate left by a prefix in slot 1 carries over to the next accepted bundle and attaches to the first real instruction there.
- R6: `fetch_ready` is 1 only in `ST_STREAM`, with `flush` low and at least two free entries. A bundle is taken only when `fetch_valid` and `fetch_ready` are both high, and when it is not taken nothing of it is stored.
- R7: `dec_valid` is 1 exactly when the queue holds an entry and `flush` is low. A bundle accepted at a clock edge is visible on the decode port right after that edge when the queue was empty. In `ST_STREAM` each valid/ready handshake frees the head entry.
- R8: A flush empties the queue, returns it to `ST_STREAM` and discards any partial immediate, all at the next edge. A bundle, a handshake or a `loop_go` presented in the flush cycle has no effect.
- R9: `loop_go` is accepted only in `ST_STREAM` with `flush` low, with 1 <= `loop_len` <= 8 and with `loop_offset` + `loop_len` <= occupancy. The body then starts `loop_offset` entries after the head. Otherwise `loop_go` is ignored.
- R10: In `ST_LOOP`, reading continues in order and wraps from the last body entry back to the first. No entry is freed, `fetch_ready` stays 0, and the state holds until a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Bundle present from instruction memory |
| fetch_ready | output | 1 | Queue can take a whole bundle this cycle |
| fetch_insn0 | input | 16 | Bundle slot 0 (earlier instruction) |
| fetch_insn1 | input | 16 | Bundle slot 1 |
| fetch_pc | input | 32 | Address of slot 0 |
| flush | input | 1 | Empty the queue and leave loop replay |
| loop_go | input | 1 | Request loop replay |
| loop_offset | input | 3 | Body start, in entries after the head |
| loop_len | input | 4 | Body length in entries (1 to 8) |
| dec_valid | output | 1 | Head entry offered to decode |
| dec_ready | input | 1 | Decode takes the offered entry |
| dec_insn | output | 16 | Offered instruction |
| dec_imm | output | 32 | Folded immediate of that instruction |
| dec_pc | output | 32 | PC of that instruction |
| dec_flags | output | 2 | [0] immediate present, [1] multi-prefix immediate |

## Verification
Every decode output and `fetch_ready` is a combinational view of registered state, so a result is due at the first clock edge after its cause. A bundle taken at edge N shows at the head after edge N. A flush at edge N leaves `dec_valid` low after edge N. A `loop_go` accepted at edge N holds `fetch_ready` low after that edge, and a replay wrap changes `dec_insn` one edge after the last body entry is taken. The bench applies each cycle's inputs on the falling edge. It checks outputs 1 ns later against a model that is advanced only once per cycle, with the handshakes that edge will perform, so every comparison sees the state of exactly one elapsed edge.

// File: rtl/insn_queue_pkg.sv
package insn_queue_pkg;

    localparam int INSN_W   = 16;
    localparam int IMM_W    = 32;
    localparam int PC_W     = 32;
    localparam int PFX_BITS = 12;
    localparam int TAG_W    = INSN_W - PFX_BITS;
    localparam int FLAG_W   = 2;
    localparam int BUNDLE   = 2;
    localparam int PC_STEP  = INSN_W / 8;
    localparam logic [TAG_W-1:0] PFX_TAG = '1;

    typedef struct packed {
        logic [INSN_W-1:0] insn;
        logic [IMM_W-1:0]  imm;
        logic [FLAG_W-1:0] flags;
        logic [PC_W-1:0]   pc;
    } iq_entry_t;

    typedef struct packed {
        logic [IMM_W-1:0] val;
        logic             live;
        logic             multi;
    } fold_acc_t;

    typedef enum logic {
        ST_STREAM = 1'b0,
        ST_LOOP   = 1'b1
    } iq_state_e;

    function automatic logic is_prefix(input logic [INSN_W-1:0] w);
        return w[INSN_W-1:PFX_BITS] == PFX_TAG;
    endfunction

endpackage

// File: rtl/insn_queue_fold.sv
module insn_queue_fold
    import insn_queue_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      take,
    input  logic [INSN_W-1:0]         insn0,
    input  logic [INSN_W-1:0]         insn1,
    input  logic [PC_W-1:0]           pc,
    output iq_entry_t [BUNDLE-1:0]    ents,
    output logic [1:0]                n_real
);

    fold_acc_t          acc_q;
    fold_acc_t          acc_d;
    logic [INSN_W-1:0]  words [BUNDLE];

    assign words[0] = insn0;
    assign words[1] = insn1;

    // Walk the bundle in program order; prefixes grow the accumulator,
    // real instructions pick it up and are packed to the low slots.
    always_comb begin
        acc_d  = acc_q;
        n_real = '0;
        ents   = '0;
        for (int k = 0; k < BUNDLE; k++) begin
            if (is_prefix(words[k])) begin
                acc_d.multi = acc_d.live;
                acc_d.val   = (acc_d.live ? (acc_d.val << PFX_BITS) : '0)
                            | IMM_W'(words[k][PFX_BITS-1:0]);
                acc_d.live  = 1'b1;
            end else begin
                ents[n_real[0]].insn  = words[k];
                ents[n_real[0]].imm   = acc_d.live ? acc_d.val : '0;
                ents[n_real[0]].flags = {acc_d.multi, acc_d.live};
                ents[n_real[0]].pc    = pc + PC_W'(k * PC_STEP);
                n_real                = n_real + 2'd1;
                acc_d                 = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            acc_q <= '0;
        end else if (take) begin
            acc_q <= acc_d;
        end
    end

    p_flush_drops_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !acc_q.live);

    p_prefix_no_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && is_prefix(insn0) && is_prefix(insn1)) |-> (n_real == 2'd0));

    p_carry_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !flush && is_prefix(insn1)) |=> acc_q.live);

endmodule

// File: rtl/insn_queue_mem.sv
module insn_queue_mem
    import insn_queue_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
)(
    input  logic             clk,
    input  logic             we0,
    input  logic             we1,
    input  logic [PTR_W-1:0] wr_ptr,
    input  iq_entry_t        ent0,
    input  iq_entry_t        ent1,
    input  logic [PTR_W-1:0] rd_ptr,
    output iq_entry_t        rd_ent
);

    iq_entry_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr1;

    assign wr_ptr1 = wr_ptr + PTR_W'(1);

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we0 && wr_ptr == PTR_W'(s)) begin
                slots[s] <= ent0;
            end else if (we1 && wr_ptr1 == PTR_W'(s)) begin
                slots[s] <= ent1;
            end
        end
    end

    assign rd_ent = slots[rd_ptr];

endmodule

// File: rtl/insn_queue_ctrl.sv
module insn_queue_ctrl
    import insn_queue_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic [1:0]       n_real,
    input  logic             flush,
    input  logic             dec_ready,
    input  logic             loop_go,
    input  logic [PTR_W-1:0] loop_offset,
    input  logic [CNT_W-1:0] loop_len,
    output logic             fetch_ready,
    output logic             take,
    output logic             we0,
    output logic             we1,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             dec_valid
);

    iq_state_e        state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [PTR_W-1:0] lstart_q, lend_q;
    logic [CNT_W-1:0] free_slots;
    logic [CNT_W:0]   span;
    logic             len_ok;
    logic             loop_ok;
    logic             in_loop;
    logic             pop;
    logic [PTR_W-1:0] start_d, end_d, eff_start, eff_end;
    logic [CNT_W-1:0] add_cnt, sub_cnt;

    assign free_slots = CNT_W'(DEPTH) - count_q;
    assign span       = (CNT_W+1)'(loop_offset) + (CNT_W+1)'(loop_len);
    assign len_ok     = (loop_len != '0) && (loop_len <= CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STREAM;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        fetch_ready = 1'b0;
        loop_ok     = 1'b0;
        unique case (state_q)
            ST_STREAM: begin
                fetch_ready = !flush && (free_slots >= CNT_W'(2));
                loop_ok     = !flush && loop_go && len_ok
                            && (span <= (CNT_W+1)'(count_q));
                if (loop_ok) begin
                    state_d = ST_LOOP;
                end
            end
            ST_LOOP: begin
                if (flush) begin
                    state_d = ST_STREAM;
                end
            end
        endcase
    end

    assign dec_valid = (count_q != '0) && !flush;
    assign take      = fetch_valid && fetch_ready;
    assign pop       = dec_valid && dec_ready;
    assign in_loop   = (state_q == ST_LOOP) || loop_ok;
    assign we0       = take && (n_real != 2'd0);
    assign we1       = take && (n_real == 2'd2);

    assign start_d   = rd_ptr + loop_offset;
    assign end_d     = start_d + PTR_W'(loop_len - CNT_W'(1));
    assign eff_start = loop_ok ? start_d : lstart_q;
    assign eff_end   = loop_ok ? end_d : lend_q;
    assign add_cnt   = take ? CNT_W'(n_real) : '0;
    assign sub_cnt   = (pop && !in_loop) ? CNT_W'(1) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            count_q  <= '0;
            lstart_q <= '0;
            lend_q   <= '0;
        end else if (flush) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (loop_ok) begin
                lstart_q <= start_d;
                lend_q   <= end_d;
            end
            if (pop) begin
                rd_ptr <= (in_loop && rd_ptr == eff_end) ? eff_start
                                                         : rd_ptr + PTR_W'(1);
            end
            if (take) begin
                wr_ptr <= wr_ptr + PTR_W'(n_real);
            end
            count_q <= count_q + add_cnt - sub_cnt;
        end
    end

    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(DEPTH));

    p_no_fetch_in_loop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP) |-> !fetch_ready);

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count_q == '0) && (state_q == ST_STREAM));

    p_loop_keeps_entries_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP && !flush) |=> (count_q == $past(count_q)));

    p_loop_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP && pop && rd_ptr == lend_q) |=> (rd_ptr == $past(lstart_q)));

    p_loop_needs_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM && loop_go && loop_len == '0) |=> (state_q == ST_STREAM));

endmodule

// File: rtl/insn_queue.sv
module insn_queue
    import insn_queue_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [INSN_W-1:0] fetch_insn0,
    input  logic [INSN_W-1:0] fetch_insn1,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic              flush,
    input  logic              loop_go,
    input  logic [PTR_W-1:0]  loop_offset,
    input  logic [CNT_W-1:0]  loop_len,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [INSN_W-1:0] dec_insn,
    output logic [IMM_W-1:0]  dec_imm,
    output logic [PC_W-1:0]   dec_pc,
    output logic [FLAG_W-1:0] dec_flags
);

    iq_entry_t [BUNDLE-1:0] ents;
    iq_entry_t              rd_ent;
    logic [1:0]             n_real;
    logic                   take, we0, we1;
    logic [PTR_W-1:0]       wr_ptr, rd_ptr;

    insn_queue_fold u_fold (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .take   (take),
        .insn0  (fetch_insn0),
        .insn1  (fetch_insn1),
        .pc     (fetch_pc),
        .ents   (ents),
        .n_real (n_real)
    );

    insn_queue_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .n_real      (n_real),
        .flush       (flush),
        .dec_ready   (dec_ready),
        .loop_go     (loop_go),
        .loop_offset (loop_offset),
        .loop_len    (loop_len),
        .fetch_ready (fetch_ready),
        .take        (take),
        .we0         (we0),
        .we1         (we1),
        .wr_ptr      (wr_ptr),
        .rd_ptr      (rd_ptr),
        .dec_valid   (dec_valid)
    );

    insn_queue_mem #(.DEPTH(DEPTH)) u_mem (
        .clk    (clk),
        .we0    (we0),
        .we1    (we1),
        .wr_ptr (wr_ptr),
        .ent0   (ents[0]),
        .ent1   (ents[1]),
        .rd_ptr (rd_ptr),
        .rd_ent (rd_ent)
    );

    assign dec_insn  = rd_ent.insn;
    assign dec_imm   = rd_ent.imm;
    assign dec_pc    = rd_ent.pc;
    assign dec_flags = rd_ent.flags;

endmodule

// File: tb/insn_queue_bench.sv
`timescale 1ns/1ps
module insn_queue_bench;

    localparam int DEPTH = 8;

    typedef struct {
        logic [15:0] insn;
        logic [31:0] imm;
        logic [1:0]  flags;
        logic [31:0] pc;
        bit          crossed;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic        fetch_ready;
    logic [15:0] fetch_insn0 = '0;
    logic [15:0] fetch_insn1 = '0;
    logic [31:0] fetch_pc = '0;
    logic        flush = 1'b0;
    logic        loop_go = 1'b0;
    logic [2:0]  loop_offset = '0;
    logic [3:0]  loop_len = '0;
    logic        dec_valid;
    logic        dec_ready = 1'b0;
    logic [15:0] dec_insn;
    logic [31:0] dec_imm;
    logic [31:0] dec_pc;
    logic [1:0]  dec_flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    exp_t        mq[$];
    logic [31:0] m_acc = '0;
    bit          m_accv = 0;
    bit          m_multi = 0;
    bit          m_loop = 0;
    int          m_off = 0;
    int          m_end = 0;
    int          m_li = 0;
    bit          prev_fl = 0;
    bit          prev_lg = 0;

    always #4 clk = ~clk;

    insn_queue u_insn_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .fetch_ready (fetch_ready),
        .fetch_insn0 (fetch_insn0),
        .fetch_insn1 (fetch_insn1),
        .fetch_pc    (fetch_pc),
        .flush       (flush),
        .loop_go     (loop_go),
        .loop_offset (loop_offset),
        .loop_len    (loop_len),
        .dec_valid   (dec_valid),
        .dec_ready   (dec_ready),
        .dec_insn    (dec_insn),
        .dec_imm     (dec_imm),
        .dec_pc      (dec_pc),
        .dec_flags   (dec_flags)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_pfx(input logic [15:0] w);
        return w[15:12] == 4'hF;
    endfunction

    function automatic logic [15:0] pfx(input logic [11:0] p);
        return {4'hF, p};
    endfunction

    function automatic logic [15:0] real_insn(input logic [11:0] p, input logic [3:0] op);
        return {(op == 4'hF) ? 4'h0 : op, p};
    endfunction

    function automatic logic [15:0] rand_word();
        if ($urandom_range(0, 99) < 30) return pfx(12'($urandom));
        return real_insn(12'($urandom), 4'($urandom_range(0, 14)));
    endfunction

    // One cycle: drive at the falling edge, check 1 ns later, advance model.
    task automatic cyc(input bit fv, input logic [15:0] a, input logic [15:0] b,
                       input logic [31:0] pc, input bit fl, input bit dr,
                       input bit lg, input int lo, input int ll);
        bit   exp_fr, exp_dv, pop, lok, carry;
        int   idx;
        exp_t e;
        logic [15:0] w [2];
        fetch_valid = fv; fetch_insn0 = a; fetch_insn1 = b; fetch_pc = pc;
        flush = fl; dec_ready = dr; loop_go = lg;
        loop_offset = 3'(lo); loop_len = 4'(ll);
        #1;
        exp_fr = !m_loop && !fl && ((DEPTH - mq.size()) >= 2);
        chk(fetch_ready == exp_fr, m_loop ? "R10" : (prev_lg ? "R9" : "R6"),
            "fetch_ready", 64'(fetch_ready), 64'(exp_fr));
        exp_dv = (mq.size() != 0) && !fl;
        chk(dec_valid == exp_dv, prev_fl ? "R8" : "R7", "dec_valid",
            64'(dec_valid), 64'(exp_dv));
        if (exp_dv && dec_valid) begin
            idx = m_loop ? m_li : 0;
            e = mq[idx];
            chk(dec_insn == e.insn, m_loop ? "R10" : "R2", "dec_insn",
                64'(dec_insn), 64'(e.insn));
            chk(dec_pc == e.pc, m_loop ? "R10" : "R2", "dec_pc",
                64'(dec_pc), 64'(e.pc));
            chk(dec_imm == e.imm, e.crossed ? "R5" : "R3", "dec_imm",
                64'(dec_imm), 64'(e.imm));
            chk(dec_flags == e.flags, "R4", "dec_flags",
                64'(dec_flags), 64'(e.flags));
        end
        pop = exp_dv && dr;
        if (fl) begin
            mq.delete();
            m_acc = '0; m_accv = 0; m_multi = 0; m_loop = 0; m_li = 0;
        end else begin
            lok = !m_loop && lg && ll >= 1 && ll <= DEPTH && (lo + ll) <= mq.size();
            if (lok) begin
                m_loop = 1; m_off = lo; m_end = lo + ll - 1; m_li = 0;
            end
            if (pop) begin
                if (m_loop) m_li = (m_li == m_end) ? m_off : m_li + 1;
                else void'(mq.pop_front());
            end
            if (fv && exp_fr) begin
                w[0] = a; w[1] = b;
                carry = m_accv;
                for (int k = 0; k < 2; k++) begin
                    if (is_pfx(w[k])) begin
                        m_multi = m_accv;
                        m_acc = (m_accv ? (m_acc << 12) : 32'h0) | 32'(w[k][11:0]);
                        m_accv = 1;
                    end else begin
                        e.insn = w[k];
                        e.imm = m_accv ? m_acc : 32'h0;
                        e.flags = {m_multi, m_accv};
                        e.pc = pc + 32'(2 * k);
                        e.crossed = carry && m_accv;
                        mq.push_back(e);
                        m_acc = '0; m_accv = 0; m_multi = 0; carry = 0;
                    end
                end
            end
        end
        prev_fl = fl;
        prev_lg = lg;
        @(negedge clk);
    endtask

    task automatic idle(input bit dr, input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, '0, '0, 0, dr, 0, 0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R7 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1BAD5EED));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(dec_valid == 1'b0, "R1", "reset dec_valid", 64'(dec_valid), 64'h0);
        chk(fetch_ready == 1'b1, "R1", "reset fetch_ready", 64'(fetch_ready), 64'h1);
        @(negedge clk);

        // R3/R4/R5: three prefixes over a bundle boundary; expect imm 32'hBC123456.
        cyc(1, pfx(12'hABC), pfx(12'h123), 32'h100, 0, 0, 0, 0, 0);
        cyc(1, pfx(12'h456), real_insn(12'h001, 4'h1), 32'h104, 0, 0, 0, 0, 0);
        chk(dec_imm == 32'hBC123456, "R5", "carried imm", 64'(dec_imm), 64'hBC123456);
        cyc(1, real_insn(12'h002, 4'h2), pfx(12'h7), 32'h108, 0, 1, 0, 0, 0);
        cyc(1, real_insn(12'h003, 4'h3), real_insn(12'h004, 4'h4), 32'h10C, 0, 1, 0, 0, 0);
        idle(1, 4);

        // R8: partial immediate dropped by a flush; bundle in flush cycle dropped.
        cyc(1, real_insn(12'h011, 4'h5), pfx(12'h0FF), 32'h200, 0, 0, 0, 0, 0);
        cyc(1, real_insn(12'h012, 4'h6), real_insn(12'h013, 4'h6), 32'h204, 1, 1, 1, 0, 2);
        cyc(1, real_insn(12'h014, 4'h7), real_insn(12'h015, 4'h7), 32'h208, 0, 0, 0, 0, 0);
        chk(dec_flags == 2'b00, "R8", "imm after flush", 64'(dec_flags), 64'h0);
        idle(1, 3);

        // R6: fill to capacity, then R9 ignored requests, then R10 replay.
        for (int i = 0; i < 6; i++)
            cyc(1, real_insn(12'(i), 4'h8), real_insn(12'(i + 16), 4'h9),
                32'h300 + 32'(4 * i), 0, 0, 0, 0, 0);
        cyc(0, '0, '0, '0, 0, 0, 1, 0, 0);
        cyc(0, '0, '0, '0, 0, 0, 1, 0, 9);
        cyc(0, '0, '0, '0, 0, 0, 1, 5, 4);
        cyc(0, '0, '0, '0, 0, 1, 1, 2, 5);
        idle(1, 20);
        cyc(1, pfx(12'h1), pfx(12'h2), 32'h400, 0, 1, 1, 0, 1);
        cyc(0, '0, '0, '0, 1, 1, 0, 0, 0);
        cyc(1, real_insn(12'h21, 4'h1), real_insn(12'h22, 4'h2), 32'h500, 0, 0, 0, 0, 0);
        cyc(1, real_insn(12'h23, 4'h1), real_insn(12'h24, 4'h2), 32'h504, 0, 0, 0, 0, 0);
        cyc(1, real_insn(12'h25, 4'h1), real_insn(12'h26, 4'h2), 32'h508, 0, 0, 0, 0, 0);
        cyc(1, real_insn(12'h27, 4'h1), real_insn(12'h28, 4'h2), 32'h50C, 0, 0, 1, 0, 8);
        idle(1, 18);
        cyc(0, '0, '0, '0, 1, 0, 0, 0, 0);

        // Constrained random mix.
        for (int i = 0; i < 4000; i++) begin
            cyc($urandom_range(0, 99) < 75, rand_word(), rand_word(),
                {$urandom_range(0, 32'h7FFF_FFFF), 1'b0}[31:0],
                m_loop ? ($urandom_range(0, 99) < 8) : ($urandom_range(0, 99) < 2),
                $urandom_range(0, 99) < 65,
                $urandom_range(0, 99) < 4,
                $urandom_range(0, 3), $urandom_range(0, 9));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule